// File: doc/BRIEF.md
# Flash Region Write Guard

This block decides which nonvolatile writes may go ahead on a chip whose program flash is split into three consecutive regions. Starting at address 0 these are the boot region, the application-code region and the application-data region. Two fuse-style size values, counted in blocks of `BLOCK_BYTES` bytes, set where the regions end. The first gives the boot size. The second gives the end of the application-code region measured from address 0, so it covers boot and code together. For every write or erase request, the guard checks the region that holds the currently executing instruction against the target (a flash region or the EEPROM port). It either forwards a one-cycle strobe to the array, or drops the request and raises a sticky error.

The guard also holds three set-only protection bits: boot read-protect, application-code write-protect and application-data write-protect. A protection-bit write takes effect only inside a short window opened by a key value. Once set, a bit stays set until reset. Boot read-protect does not act at once. It arms on the first cycle that execution is seen outside the boot region. From then on, every read or instruction fetch that falls in the boot region returns zero.

Top module: `nvm_region_guard`

## Requirements
- R1: When the boot size value is 0 the whole flash decodes as boot region, so every CPU flash write or erase is denied and executing code counts as boot code (EEPROM writes allowed).
- R2: Addresses below bootSize*BLOCK_BYTES are boot. Addresses from there up to codeSize*BLOCK_BYTES are application code. Everything above is application data. An address equal to a boundary belongs to the upper region.
- R3: Code executing in the data region has every CPU write or erase denied, including EEPROM requests.
- R4: Code executing in the application-code region may write or erase EEPROM and the data region. Requests to the code or boot regions are denied.
- R5: Code executing in the boot region may write or erase EEPROM, the data region and the code region. Requests that target the boot region are denied.
- R6: A request flagged as coming from the external programming port is granted for any target, including the boot region, regardless of protection bits.
- R7: After boot read-protect is set, `rpActive` rises one cycle after `pcAddr` is first sampled outside the boot region and never falls before reset. While it is high, `rdData` is 0 for boot-region `rdAddr` and equals `rdRaw` otherwise. Before it rises, `rdData` equals `rdRaw`.
- R8: With the code write-protect bit set, CPU writes to the code region are denied. With the data write-protect bit set, CPU writes to the data region are denied.
- R9: A `keyStrobe` carrying `keyValue == KEY` opens a window for protection writes sampled on the 1st through 4th following clock edges. A `lockWrite` at any other time, or after a wrong key, is ignored. Writing a bit as 0 never clears it.
- R10: A denied request raises `errFlag` one cycle later and produces no strobe. `errFlag` stays high until a cycle with `errClear` and no new denial, after which it reads 0.
- R11: A granted request raises exactly one of `flashWrEn`, `flashErEn` or `eepWrEn` for the single cycle after the request, with `cmdAddr` equal to the request address.
- R12: `lockData`/`lockState` bit 0 is boot read-protect, bit 1 is code write-protect, bit 2 is data write-protect. Bit 0 is accepted only while `pcAddr` is in the boot region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears protection bits, arming and error |
| bootSize | input | SIZE_W | Boot region size in blocks |
| codeSize | input | SIZE_W | End of code region in blocks (boot plus code) |
| pcAddr | input | ADDR_W | Byte address of the executing instruction |
| reqValid | input | 1 | Write/erase request present this cycle |
| reqErase | input | 1 | 1 = erase, 0 = write |
| reqEeprom | input | 1 | Request targets the EEPROM port rather than flash |
| reqExt | input | 1 | Request comes from the external programming port |
| reqAddr | input | ADDR_W | Flash byte address of the request |
| flashWrEn | output | 1 | Granted flash write strobe |
| flashErEn | output | 1 | Granted flash erase strobe |
| eepWrEn | output | 1 | Granted EEPROM write/erase strobe |
| cmdAddr | output | ADDR_W | Address belonging to the strobe |
| rdAddr | input | ADDR_W | Read / fetch address |
| rdRaw | input | DATA_W | Raw word from the array |
| rdData | output | DATA_W | Word after read-protect masking |
| keyStrobe | input | 1 | Key write |
| keyValue | input | 8 | Key value |
| lockWrite | input | 1 | Protection-bit write |
| lockData | input | 3 | Bits to set (bit0 boot RP, bit1 code WP, bit2 data WP) |
| lockState | output | 3 | Current protection bits |
| rpActive | output | 1 | Boot read-protect armed |
| errClear | input | 1 | Clears the error flag |
| errFlag | output | 1 | Sticky denied-access flag |

## Verification
The assertions assume that `bootSize` does not exceed `codeSize` and that the size values stay constant around a request. The checker infers the source and target regions of a strobe from the values it captured one cycle earlier. They also assume reset is applied from time zero. The stimulus changes the size values only while no request is in flight, always keeps the boot size no larger than the code size, and drives `pcAddr` on the falling edge so that each request sees a settled region.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [1:0] {
    RG_BOOT = 2'd0,
    RG_CODE = 2'd1,
    RG_DATA = 2'd2
  } region_e;

  // bit positions of the protection word
  localparam int LK_BOOT_RP = 0;
  localparam int LK_CODE_WP = 1;
  localparam int LK_DATA_WP = 2;
  localparam int LK_BITS    = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic codeWp;
    logic dataWp;
    logic rpArmed;
  } guard_ctl_s;

endpackage

// File: rtl/nvm_region_decode.sv
module nvm_region_decode
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 8,
  parameter int BLOCK_SHIFT = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] bootSize,
  input  logic [SIZE_W-1:0] codeSize,
  output region_e           region
);
  localparam int CMP_W = ADDR_W + SIZE_W + BLOCK_SHIFT;

  logic [CMP_W-1:0] addrW;
  logic [CMP_W-1:0] bootEnd;
  logic [CMP_W-1:0] codeEnd;

  assign addrW   = CMP_W'(addr);
  assign bootEnd = CMP_W'(bootSize) << BLOCK_SHIFT;
  assign codeEnd = CMP_W'(codeSize) << BLOCK_SHIFT;

  always_comb begin
    if (bootSize == '0 || addrW < bootEnd) region = RG_BOOT;
    else if (addrW < codeEnd)              region = RG_CODE;
    else                                   region = RG_DATA;
  end
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int          WINDOW = 4,
  parameter logic [7:0]  KEY    = 8'h9D
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               keyStrobe,
  input  logic [7:0]         keyValue,
  input  logic               lockWrite,
  input  logic [LK_BITS-1:0] lockData,
  input  logic               errClear,
  input  logic               denyPulse,
  input  logic               pcInBoot,
  output guard_ctl_s         ctl,
  output logic [LK_BITS-1:0] lockState,
  output logic               errFlag
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0]   winCnt;
  logic [LK_BITS-1:0] lockBits;
  logic               rpArmed;
  logic               winOpen;
  logic [LK_BITS-1:0] setMask;

  assign winOpen = (winCnt != '0);

  always_comb begin
    setMask             = lockData;
    setMask[LK_BOOT_RP] = lockData[LK_BOOT_RP] & pcInBoot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (keyStrobe && keyValue == KEY) begin
      winCnt <= WIN_W'(WINDOW);
    end else if (winOpen) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits <= '0;
    end else if (lockWrite && winOpen) begin
      lockBits <= lockBits | setMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rpArmed <= 1'b0;
    else       rpArmed <= rpArmed | (lockBits[LK_BOOT_RP] & ~pcInBoot);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (denyPulse) errFlag <= 1'b1;
    else if (errClear)  errFlag <= 1'b0;
  end

  assign ctl.codeWp  = lockBits[LK_CODE_WP];
  assign ctl.dataWp  = lockBits[LK_DATA_WP];
  assign ctl.rpArmed = rpArmed;
  assign lockState   = lockBits;
endmodule

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BLOCK_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] bootSize,
  input  logic [SIZE_W-1:0] codeSize,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic              reqEeprom,
  input  logic              reqExt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdRaw,
  input  guard_ctl_s        ctl,
  output logic              flashWrEn,
  output logic              flashErEn,
  output logic              eepWrEn,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              denyPulse,
  output logic              pcInBoot
);
  localparam int N_DEC  = 3;
  localparam int DEC_PC = 0;
  localparam int DEC_RQ = 1;
  localparam int DEC_RD = 2;

  logic [ADDR_W-1:0] decAddr [N_DEC];
  region_e           decReg  [N_DEC];
  logic              allow;

  assign decAddr[DEC_PC] = pcAddr;
  assign decAddr[DEC_RQ] = reqAddr;
  assign decAddr[DEC_RD] = rdAddr;

  for (genvar i = 0; i < N_DEC; i++) begin : g_dec
    nvm_region_decode #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BLOCK_SHIFT(BLOCK_SHIFT)
    ) u_dec (
      .addr(decAddr[i]), .bootSize(bootSize), .codeSize(codeSize),
      .region(decReg[i])
    );
  end

  // permission matrix: source region of execution vs target
  always_comb begin
    allow = 1'b0;
    if (reqExt) begin
      allow = 1'b1;
    end else if (reqEeprom) begin
      allow = (decReg[DEC_PC] != RG_DATA);
    end else begin
      unique case (decReg[DEC_RQ])
        RG_CODE: allow = (decReg[DEC_PC] == RG_BOOT) && !ctl.codeWp;
        RG_DATA: allow = (decReg[DEC_PC] != RG_DATA) && !ctl.dataWp;
        default: allow = 1'b0;
      endcase
    end
  end

  assign denyPulse = reqValid & ~allow;
  assign pcInBoot  = (decReg[DEC_PC] == RG_BOOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashWrEn <= 1'b0;
      flashErEn <= 1'b0;
      eepWrEn   <= 1'b0;
      cmdAddr   <= '0;
    end else begin
      flashWrEn <= reqValid & allow & ~reqEeprom & ~reqErase;
      flashErEn <= reqValid & allow & ~reqEeprom & reqErase;
      eepWrEn   <= reqValid & allow & reqEeprom;
      if (reqValid) cmdAddr <= reqAddr;
    end
  end

  assign rdData = (ctl.rpArmed && decReg[DEC_RD] == RG_BOOT) ? '0 : rdRaw;
endmodule

// File: rtl/nvm_region_guard.sv
module nvm_region_guard
  import nvm_guard_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         SIZE_W      = 8,
  parameter int         DATA_W      = 16,
  parameter int         BLOCK_BYTES = 256,
  parameter int         WINDOW      = 4,
  parameter logic [7:0] KEY         = 8'h9D
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SIZE_W-1:0]  bootSize,
  input  logic [SIZE_W-1:0]  codeSize,
  input  logic [ADDR_W-1:0]  pcAddr,
  input  logic               reqValid,
  input  logic               reqErase,
  input  logic               reqEeprom,
  input  logic               reqExt,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               flashWrEn,
  output logic               flashErEn,
  output logic               eepWrEn,
  output logic [ADDR_W-1:0]  cmdAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  rdRaw,
  output logic [DATA_W-1:0]  rdData,
  input  logic               keyStrobe,
  input  logic [7:0]         keyValue,
  input  logic               lockWrite,
  input  logic [LK_BITS-1:0] lockData,
  output logic [LK_BITS-1:0] lockState,
  output logic               rpActive,
  input  logic               errClear,
  output logic               errFlag
);
  localparam int BLOCK_SHIFT = $clog2(BLOCK_BYTES);

  guard_ctl_s ctl;
  logic       denyPulse;
  logic       pcInBoot;

  nvm_guard_ctrl #(.WINDOW(WINDOW), .KEY(KEY)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .keyStrobe(keyStrobe), .keyValue(keyValue),
    .lockWrite(lockWrite), .lockData(lockData),
    .errClear(errClear), .denyPulse(denyPulse), .pcInBoot(pcInBoot),
    .ctl(ctl), .lockState(lockState), .errFlag(errFlag)
  );

  nvm_guard_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .BLOCK_SHIFT(BLOCK_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .bootSize(bootSize), .codeSize(codeSize), .pcAddr(pcAddr),
    .reqValid(reqValid), .reqErase(reqErase), .reqEeprom(reqEeprom),
    .reqExt(reqExt), .reqAddr(reqAddr),
    .rdAddr(rdAddr), .rdRaw(rdRaw), .ctl(ctl),
    .flashWrEn(flashWrEn), .flashErEn(flashErEn), .eepWrEn(eepWrEn),
    .cmdAddr(cmdAddr), .rdData(rdData),
    .denyPulse(denyPulse), .pcInBoot(pcInBoot)
  );

  assign rpActive = ctl.rpArmed;
endmodule

// File: rtl/nvm_region_guard_chk.sv
module nvm_region_guard_chk #(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BLOCK_BYTES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic [SIZE_W-1:0] bootSize,
  input logic [SIZE_W-1:0] codeSize,
  input logic [ADDR_W-1:0] pcAddr,
  input logic              reqValid,
  input logic              reqExt,
  input logic              flashWrEn,
  input logic              flashErEn,
  input logic              eepWrEn,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [2:0]        lockState,
  input logic              rpActive,
  input logic              errFlag
);
  localparam int SHIFT = $clog2(BLOCK_BYTES);
  localparam int CMP_W = ADDR_W + SIZE_W + SHIFT;

  logic              prevExt;
  logic [SIZE_W-1:0] prevBoot;
  logic [SIZE_W-1:0] prevCode;
  logic [ADDR_W-1:0] prevPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevExt  <= 1'b0;
      prevBoot <= '0;
      prevCode <= '0;
      prevPc   <= '0;
    end else begin
      prevExt  <= reqExt;
      prevBoot <= bootSize;
      prevCode <= codeSize;
      prevPc   <= pcAddr;
    end
  end

  function automatic logic [CMP_W-1:0] endOf(input logic [SIZE_W-1:0] sz);
    return CMP_W'(sz) << SHIFT;
  endfunction

  AST_NO_CPU_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrEn || flashErEn) && !prevExt |->
      (prevBoot != '0) && (CMP_W'(cmdAddr) >= endOf(prevBoot))); // R5

  AST_DATA_NO_EEPROM: assert property (@(posedge clk) disable iff (!rstN)
    eepWrEn && !prevExt |->
      (prevBoot == '0) || (CMP_W'(prevPc) < endOf(prevBoot)) ||
      (CMP_W'(prevPc) < endOf(prevCode))); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashWrEn, flashErEn, eepWrEn})); // R11

  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (flashWrEn || flashErEn || eepWrEn || errFlag)); // R10

  AST_LOCK_SET_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockState) & ~lockState) == 3'b000); // R9

  AST_RP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(rpActive)); // R7

  AST_RP_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rpActive && bootSize != '0 && CMP_W'(rdAddr) < endOf(bootSize) |->
      rdData == '0); // R7
endmodule

bind nvm_region_guard nvm_region_guard_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (.*);

// File: tb/nvm_region_guard_tb.sv
module nvm_region_guard_tb;
  localparam int         ADDR_W = 16;
  localparam int         SIZE_W = 8;
  localparam int         DATA_W = 16;
  localparam int         BLK    = 256;
  localparam logic [7:0] KEY    = 8'h9D;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [SIZE_W-1:0] bootSize = 8'd4;
  logic [SIZE_W-1:0] codeSize = 8'd16;
  logic [ADDR_W-1:0] pcAddr = 16'h0100;
  logic              reqValid = 0, reqErase = 0, reqEeprom = 0, reqExt = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              flashWrEn, flashErEn, eepWrEn;
  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdRaw = '0;
  logic [DATA_W-1:0] rdData;
  logic              keyStrobe = 0;
  logic [7:0]        keyValue = '0;
  logic              lockWrite = 0;
  logic [2:0]        lockData = '0;
  logic [2:0]        lockState;
  logic              rpActive;
  logic              errClear = 0;
  logic              errFlag;

  always #5 clk = ~clk;

  nvm_region_guard #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W),
                     .BLOCK_BYTES(BLK), .KEY(KEY)) u_dut (.*);

  int  nChecks = 0;
  int  nFails  = 0;
  int  cyc     = 0;
  bit  done    = 0;
  logic       mErr = 0;
  logic [2:0] mLock = '0;

  typedef struct {
    int          due;
    logic [3:0]  strb;   // {wr, er, ee, err}
    logic [15:0] addr;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // region model from the requirement text (R2, R1)
  function automatic int regionOf(input logic [15:0] a);
    if (bootSize == 0) return 0;
    if (int'(a) < int'(bootSize) * BLK) return 0;
    if (int'(a) < int'(codeSize) * BLK) return 1;
    return 2;
  endfunction

  function automatic bit permitted(input bit ee, input bit ext, input logic [15:0] a);
    int src, tgt;
    src = regionOf(pcAddr);
    tgt = regionOf(a);
    if (ext) return 1;
    if (ee)  return src != 2;
    if (tgt == 1) return src == 0 && !mLock[1];
    if (tgt == 2) return src != 2 && !mLock[2];
    return 0;
  endfunction

  // monitor: pops scoreboard items in their due cycle
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      logic [3:0] act;
      e = sbq.pop_front();
      act = {flashWrEn, flashErEn, eepWrEn, errFlag};
      chk(act == e.strb, {e.tag, " strobes/err"}, 32'(act), 32'(e.strb));
      if (e.strb[3:1] != 3'b000)
        chk(cmdAddr == e.addr, {e.tag, " R11 cmdAddr"}, 32'(cmdAddr), 32'(e.addr));
    end
  end

  // driver: caller sits just after a falling edge
  task automatic doReq(input bit er, input bit ee, input bit ext,
                       input logic [15:0] a, input string tag);
    exp_t e;
    bit ok;
    ok = permitted(ee, ext, a);
    if (!ok) mErr = 1;
    else if (errClear) mErr = 0;
    e.due  = cyc + 1;
    e.strb = {ok && !ee && !er, ok && !ee && er, ok && ee, mErr};
    e.addr = a;
    e.tag  = tag;
    sbq.push_back(e);
    reqValid = 1; reqErase = er; reqEeprom = ee; reqExt = ext; reqAddr = a;
    @(negedge clk);
    reqValid = 0; reqErase = 0; reqEeprom = 0; reqExt = 0;
  endtask

  task automatic clearErr();
    errClear = 1;
    @(negedge clk);
    errClear = 0;
    mErr = 0;
  endtask

  task automatic setPc(input logic [15:0] a);
    pcAddr = a;
    @(negedge clk);
  endtask

  task automatic keyPulse(input logic [7:0] v);
    keyStrobe = 1; keyValue = v;
    @(negedge clk);
    keyStrobe = 0;
  endtask

  task automatic lockPulse(input logic [2:0] d);
    lockWrite = 1; lockData = d;
    @(negedge clk);
    lockWrite = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readChk(input logic [15:0] a, input logic [15:0] raw,
                         input logic [15:0] exp, input string tag);
    rdAddr = a; rdRaw = raw;
    #1;
    chk(rdData == exp, tag, 32'(rdData), 32'(exp));
  endtask

  initial begin
    idle(3);
    chk({flashWrEn, flashErEn, eepWrEn, errFlag, rpActive, lockState} == '0,
        "R10 reset state", 32'({flashWrEn, flashErEn, eepWrEn, errFlag, rpActive, lockState}), 0);
    rstN = 1;
    idle(1);

    // R5: executing from boot
    setPc(16'h0100);
    doReq(0, 0, 0, 16'h0800, "R5 boot->code write");
    doReq(1, 0, 0, 16'h0900, "R5 boot->code erase");
    doReq(0, 1, 0, 16'h0000, "R5 boot->eeprom");
    doReq(0, 0, 0, 16'h2000, "R5 boot->data write");
    doReq(0, 0, 0, 16'h0010, "R5 boot->boot denied");
    idle(3);
    chk(errFlag == 1, "R10 error sticky", 32'(errFlag), 1);
    clearErr();
    chk(errFlag == 0, "R10 error cleared", 32'(errFlag), 0);

    // R4: executing from code
    setPc(16'h0500);
    doReq(0, 1, 0, 16'h0000, "R4 code->eeprom");
    doReq(0, 0, 0, 16'h3000, "R4 code->data");
    doReq(0, 0, 0, 16'h0600, "R4 code->code denied");
    doReq(1, 0, 0, 16'h0000, "R4 code->boot denied");
    clearErr();

    // R3: executing from data
    setPc(16'h3000);
    doReq(0, 1, 0, 16'h0000, "R3 data->eeprom denied");
    doReq(0, 0, 0, 16'h3100, "R3 data->data denied");
    doReq(0, 0, 0, 16'h0800, "R3 data->code denied");
    clearErr();

    // R6: external port
    doReq(0, 0, 1, 16'h0000, "R6 ext boot write");
    doReq(1, 0, 1, 16'h0200, "R6 ext boot erase");

    // R2: boundaries
    setPc(16'h03FF);
    doReq(0, 0, 0, 16'h0400, "R2 pc 0x3FF is boot");
    setPc(16'h0400);
    doReq(0, 0, 0, 16'h0400, "R2 pc 0x400 is code");
    doReq(0, 0, 0, 16'h0FFF, "R2 0xFFF is code");
    doReq(0, 0, 0, 16'h1000, "R2 0x1000 is data");
    clearErr();

    // R1: boot size zero
    idle(2);
    bootSize = 0;
    setPc(16'h3000);
    doReq(0, 0, 0, 16'h3000, "R1 all boot, flash denied");
    doReq(0, 1, 0, 16'h0000, "R1 all boot, eeprom ok");
    clearErr();
    idle(2);
    bootSize = 4;

    // R10: clear and deny in the same cycle
    setPc(16'h0500);
    errClear = 1;
    doReq(0, 0, 0, 16'h0010, "R10 deny beats clear");
    errClear = 0;
    chk(errFlag == 1, "R10 deny beats clear flag", 32'(errFlag), 1);
    clearErr();

    // R9: key window
    setPc(16'h0100);
    lockPulse(3'b010);
    chk(lockState == 3'b000, "R9 no key ignored", 32'(lockState), 0);
    keyPulse(8'h55);
    lockPulse(3'b010);
    chk(lockState == 3'b000, "R9 wrong key ignored", 32'(lockState), 0);
    keyPulse(KEY); idle(4); lockPulse(3'b010);
    chk(lockState == 3'b000, "R9 5th edge ignored", 32'(lockState), 0);
    keyPulse(KEY); idle(3); lockPulse(3'b010);
    mLock = 3'b010;
    chk(lockState == 3'b010, "R9 4th edge accepted", 32'(lockState), 32'h2);

    // R8 code WP
    doReq(0, 0, 0, 16'h0800, "R8 code WP denies boot->code");
    doReq(0, 0, 0, 16'h2000, "R8 data still writable");
    doReq(0, 0, 1, 16'h0800, "R6 ext ignores code WP");
    clearErr();

    // R12: boot RP only from boot
    setPc(16'h0500);
    keyPulse(KEY); lockPulse(3'b001);
    chk(lockState == 3'b010, "R12 boot RP from code ignored", 32'(lockState), 32'h2);

    // R7: read protect arming
    setPc(16'h0100);
    keyPulse(KEY); lockPulse(3'b001);
    mLock = 3'b011;
    chk(lockState == 3'b011, "R12 boot RP bit0 set", 32'(lockState), 32'h3);
    idle(1);
    chk(rpActive == 0, "R7 not armed inside boot", 32'(rpActive), 0);
    readChk(16'h0020, 16'hBEEF, 16'hBEEF, "R7 boot read before arming");
    setPc(16'h0600);
    chk(rpActive == 1, "R7 armed on crossing", 32'(rpActive), 1);
    readChk(16'h0020, 16'hBEEF, 16'h0000, "R7 boot read masked");
    readChk(16'h0700, 16'h1234, 16'h1234, "R7 code read unmasked");
    setPc(16'h0100);
    idle(1);
    chk(rpActive == 1, "R7 stays armed", 32'(rpActive), 1);
    readChk(16'h03FE, 16'hA5A5, 16'h0000, "R7 boot fetch masked after return");

    // R9 set-only and R8 data WP
    keyPulse(KEY); lockPulse(3'b000);
    chk(lockState == 3'b011, "R9 zero write keeps bits", 32'(lockState), 32'h3);
    keyPulse(KEY); lockPulse(3'b100);
    mLock = 3'b111;
    chk(lockState == 3'b111, "R9 data WP set", 32'(lockState), 32'h7);
    doReq(0, 0, 0, 16'h2000, "R8 data WP denies");
    doReq(0, 0, 1, 16'h2000, "R6 ext ignores data WP");
    idle(3);
    chk(sbq.size() == 0, "R11 scoreboard drained", 32'(sbq.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule